// File: doc/BRIEF.md
# Byte Permute and Pack Unit

This block rearranges bytes. It joins two 32-bit operands into one 64-bit source word. Any source byte can then be steered to any destination byte by a 24-bit control word. Each destination lane has its own 3-bit selector, so a source byte may be copied into several lanes or into none. The registered 64-bit result presents the permuted word. The 32-bit result is its lower half.

Four half-word pack operations use the same crossbar. When pack mode is enabled, a small decoder replaces the external control word with a fixed control word for the chosen pack. The caller does not need to build selector patterns for these common merges. An operation is accepted on a cycle where the valid strobe is high, and its result appears after one register stage.

Top module: `byte_perm_unit`

## Requirements
- R1: The 64-bit source is `{op_b, op_a}`. Source byte k is bits [8k+7:8k]. Bytes 0..3 (named A..D) come from `op_a` and bytes 4..7 (E..H) come from `op_b`.
- R2: With `pack_en` low, the 3-bit field `perm_ctrl[3i+2:3i]` holds a source byte index 0..7. That byte is placed in destination byte i of `res64`.
- R3: Selectors are independent, so a source byte may appear in several destination lanes or in none. For example, selectors 0,0,6,7,5,4,3,2 for lanes 7..0 give bytes A,A,G,H,F,E,D,C from most to least significant.
- R4: With `pack_en` high, `perm_ctrl` is ignored and the lower 32 bits follow `pack_sel`. The encodings are 0 = `{op_b[31:16], op_a[15:0]}`, 1 = `{op_b[15:0], op_a[15:0]}`, 2 = `{op_b[31:16], op_a[31:16]}` and 3 = `{op_b[15:0], op_a[31:16]}`.
- R5: In pack mode the upper four destination lanes select source bytes 4..7 in order, so `res64[63:32]` equals `op_b`.
- R6: `res32` always equals `res64[31:0]`, in permute mode and in every pack mode.
- R7: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise.
- R8: When `in_valid` is low, `res64` and `res32` keep their previous values.
- R9: A synchronous active-high `rst` clears `res64`, `res32` and `out_valid` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accepts the operands and controls this cycle |
| op_a | input | 32 | First operand, source bytes 0..3 |
| op_b | input | 32 | Second operand, source bytes 4..7 |
| perm_ctrl | input | 24 | Eight 3-bit destination selectors, lane i at [3i+2:3i] |
| pack_en | input | 1 | Selects a fixed pack pattern instead of `perm_ctrl` |
| pack_sel | input | 2 | Pack pattern: 0 hi/lo, 1 lo/lo, 2 hi/hi, 3 lo/hi |
| res64 | output | 64 | Registered permuted word |
| res32 | output | 32 | Registered pack/permute result, lower half of `res64` |
| out_valid | output | 1 | High one cycle after an accepted input |

## Verification
The assertions assume that `rst` is asserted before any check is relied on. They also assume that operands and controls are sampled only on cycles where `in_valid` is high. No value is assumed on the data inputs while `in_valid` is low. The stimulus changes every input only at the falling clock edge and lowers `in_valid` between single operations, except for an explicit back-to-back run. Operand and control values are arbitrary, because every 3-bit selector value and every `pack_sel` code is legal.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
    localparam int LANES   = 8;
    localparam int BYTE_W  = 8;
    localparam int SEL_W   = $clog2(LANES);
    localparam int CTRL_W  = LANES * SEL_W;
    localparam int WORD_W  = LANES * BYTE_W;
    localparam int OP_W    = WORD_W / 2;
    localparam int HALF_LN = LANES / 4;   // bytes per half-word of an operand

    typedef enum logic [1:0] {
        PK_HL = 2'd0,
        PK_LL = 2'd1,
        PK_HH = 2'd2,
        PK_LH = 2'd3
    } pack_mode_e;

    typedef logic [SEL_W-1:0]  sel_t;
    typedef logic [CTRL_W-1:0] ctrl_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic  valid;
        word_t data;
    } perm_res_t;

    // Preset control word for one pack pattern.
    function automatic ctrl_t pack_ctrl(pack_mode_e m);
        ctrl_t c;
        logic  b_hi;
        logic  a_hi;
        int    base;
        c    = '0;
        b_hi = (m == PK_HL) || (m == PK_HH);
        a_hi = (m == PK_HH) || (m == PK_LH);
        for (int i = 0; i < LANES; i++) begin
            if (i < HALF_LN) begin
                base = a_hi ? HALF_LN : 0;
                c[i*SEL_W +: SEL_W] = SEL_W'(base + i);
            end else if (i < 2 * HALF_LN) begin
                base = LANES / 2 + (b_hi ? HALF_LN : 0);
                c[i*SEL_W +: SEL_W] = SEL_W'(base + i - HALF_LN);
            end else begin
                c[i*SEL_W +: SEL_W] = SEL_W'(i);
            end
        end
        return c;
    endfunction
endpackage

// File: rtl/bpu_ctrl_sel.sv
module bpu_ctrl_sel
    import bpu_pkg::*;
(
    input  ctrl_t      ext_ctrl,
    input  logic       pack_en,
    input  pack_mode_e pack_mode,
    output ctrl_t      eff_ctrl
);
    ctrl_t preset;

    always_comb begin
        preset   = pack_ctrl(pack_mode);
        eff_ctrl = pack_en ? preset : ext_ctrl;
    end
endmodule

// File: rtl/bpu_xbar.sv
module bpu_xbar
    import bpu_pkg::*;
(
    input  word_t src,
    input  ctrl_t ctrl,
    output word_t dst
);
    logic [BYTE_W-1:0] src_byte [LANES];

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            assign src_byte[k] = src[k*BYTE_W +: BYTE_W];
            assign dst[k*BYTE_W +: BYTE_W] = src_byte[ctrl[k*SEL_W +: SEL_W]];
        end
    endgenerate
endmodule

// File: rtl/byte_perm_unit.sv
module byte_perm_unit
    import bpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    input  logic [CTRL_W-1:0] perm_ctrl,
    input  logic              pack_en,
    input  logic [1:0]        pack_sel,
    output logic [WORD_W-1:0] res64,
    output logic [OP_W-1:0]   res32,
    output logic              out_valid
);
    word_t     src_word;
    ctrl_t     eff_ctrl;
    word_t     xbar_out;
    perm_res_t res_q;

    assign src_word = {op_b, op_a};

    bpu_ctrl_sel u_ctrl (
        .ext_ctrl  (perm_ctrl),
        .pack_en   (pack_en),
        .pack_mode (pack_mode_e'(pack_sel)),
        .eff_ctrl  (eff_ctrl)
    );

    bpu_xbar u_xbar (
        .src  (src_word),
        .ctrl (eff_ctrl),
        .dst  (xbar_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid <= in_valid;
            if (in_valid) res_q.data <= xbar_out;
        end
    end

    assign res64     = res_q.data;
    assign res32     = res_q.data[OP_W-1:0];
    assign out_valid = res_q.valid;

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && res64 == '0));

    // R7
    valid_lag_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R7
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(res64));

    // R4
    pack_hl_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pack_en && pack_sel == 2'd0) |=>
        res32 == {$past(op_b[31:16]), $past(op_a[15:0])});

    // R4
    pack_lh_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pack_en && pack_sel == 2'd3) |=>
        res32 == {$past(op_b[15:0]), $past(op_a[31:16])});

    // R5
    pack_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pack_en) |=> res64[63:32] == $past(op_b));

    // R2
    identity_perm_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !pack_en && perm_ctrl == 24'hFAC688) |=>
        res64 == {$past(op_b), $past(op_a)});
endmodule

// File: tb/byte_perm_unit_test.sv
`timescale 1ns/1ps
module byte_perm_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] op_a, op_b;
    logic [23:0] perm_ctrl;
    logic        pack_en;
    logic [1:0]  pack_sel;
    logic [63:0] res64;
    logic [31:0] res32;
    logic        out_valid;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    byte_perm_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .perm_ctrl(perm_ctrl), .pack_en(pack_en), .pack_sel(pack_sel),
        .res64(res64), .res32(res32), .out_valid(out_valid)
    );

    function automatic logic [23:0] sels(input int s7, s6, s5, s4, s3, s2, s1, s0);
        return {3'(s7), 3'(s6), 3'(s5), 3'(s4), 3'(s3), 3'(s2), 3'(s1), 3'(s0)};
    endfunction

    function automatic logic [63:0] ref_perm(input logic [31:0] a, b, input logic [23:0] c);
        logic [63:0] s, d;
        s = {b, a};
        for (int i = 0; i < 8; i++) d[i*8 +: 8] = s[c[i*3 +: 3]*8 +: 8];
        return d;
    endfunction

    task automatic chk64(input string req, input logic [63:0] act, exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // One accepted operation; checks the registered outputs one edge later.
    task automatic run_op(input string req, input logic [31:0] a, b, input logic [23:0] c,
                          input logic pe, input logic [1:0] ps, input logic [63:0] exp);
        @(negedge clk);
        op_a = a; op_b = b; perm_ctrl = c; pack_en = pe; pack_sel = ps; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk64(req, res64, exp);
        chk64({req, " R6"}, {32'h0, res32}, {32'h0, exp[31:0]});
        chk1({req, " R7"}, out_valid, 1'b1);
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0;
        perm_ctrl = '0; pack_en = 1'b0; pack_sel = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk64("R9 res64 after reset", res64, 64'h0);
        chk1("R9 valid after reset", out_valid, 1'b0);
    endtask

    task automatic t_identity;   // R1 R2
        run_op("R1 identity", 32'h4433_2211, 32'h8877_6655,
               sels(7,6,5,4,3,2,1,0), 1'b0, 2'd0, 64'h8877_6655_4433_2211);
    endtask

    task automatic t_dup;        // R3
        run_op("R3 AAGHFEDC", 32'h4433_2211, 32'h8877_6655,
               sels(0,0,6,7,5,4,3,2), 1'b0, 2'd0, 64'h1111_7788_6655_4433);
        run_op("R3 broadcast H", 32'hDEAD_BEEF, 32'hA5C3_0F1E,
               sels(7,7,7,7,7,7,7,7), 1'b0, 2'd0, {8{8'hA5}});
    endtask

    task automatic t_misc_perm;  // R2
        logic [23:0] c;
        c = sels(0,1,2,3,4,5,6,7);
        run_op("R2 reverse", 32'h0123_4567, 32'h89AB_CDEF, c, 1'b0, 2'd0,
               ref_perm(32'h0123_4567, 32'h89AB_CDEF, c));
        c = sels(3,6,1,4,7,2,5,0);
        run_op("R2 scatter", 32'hCAFE_F00D, 32'h1357_9BDF, c, 1'b0, 2'd0,
               ref_perm(32'hCAFE_F00D, 32'h1357_9BDF, c));
    endtask

    task automatic t_pack;       // R4 R5, external control is a scramble that must be ignored
        logic [31:0] a, b;
        a = 32'hA3A2_A1A0; b = 32'hB3B2_B1B0;
        run_op("R4 pack hl", a, b, sels(0,0,0,0,0,0,0,0), 1'b1, 2'd0, {b, b[31:16], a[15:0]});
        run_op("R4 pack ll", a, b, sels(1,2,3,4,5,6,7,0), 1'b1, 2'd1, {b, b[15:0],  a[15:0]});
        run_op("R4 pack hh", a, b, sels(7,7,7,7,7,7,7,7), 1'b1, 2'd2, {b, b[31:16], a[31:16]});
        run_op("R5 pack lh", a, b, sels(2,2,2,2,2,2,2,2), 1'b1, 2'd3, {b, b[15:0],  a[31:16]});
    endtask

    task automatic t_hold;       // R8 R7
        @(negedge clk);
        op_a = 32'hFFFF_FFFF; op_b = 32'h0; perm_ctrl = '0; pack_en = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        chk64("R8 hold res64", res64, {32'hB3B2_B1B0, 32'hB1B0_A3A2});
        chk1("R7 valid low when idle", out_valid, 1'b0);
    endtask

    task automatic t_back2back;  // R7 R2
        @(negedge clk);
        op_a = 32'h0000_00AA; op_b = 32'h0; perm_ctrl = sels(0,0,0,0,0,0,0,0);
        pack_en = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        chk64("R2 b2b first", res64, {8{8'hAA}});
        chk1("R7 b2b first", out_valid, 1'b1);
        op_b = 32'h5500_0000; perm_ctrl = sels(7,7,7,7,7,7,7,7);
        @(negedge clk);
        in_valid = 1'b0;
        chk64("R2 b2b second", res64, {8{8'h55}});
        chk1("R7 b2b second", out_valid, 1'b1);
    endtask

    task automatic t_reset_mid;  // R9
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk64("R9 mid reset res64", res64, 64'h0);
        chk1("R9 mid reset valid", out_valid, 1'b0);
    endtask

    initial begin
        #(20 * 5000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_identity();
        t_dup();
        t_misc_perm();
        t_pack();
        t_hold();
        t_back2back();
        t_reset_mid();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule